// File: doc/BRIEF.md
# Low-Toggle Scan Input Selector

During logic self-test, this block generates the bits that enter a group of scan chains on each shift cycle. At the head of every chain there is a two-way selector. The selector either passes a fresh bit from a shared pseudorandom register, or it repeats the bit that the same chain took on its previous shift. A repeated bit leaves no transition between neighbouring scan cells, so frequent repeats lower the switching activity while test data is shifted in.

A weighted random decision picks between repeat and fresh data. The 3-bit weight `w` sets the chance of fresh data to 2^-w. A per-chain bypass mask holds selected chains in fully random mode, which limits the loss of test quality. Each `scan_in` bit is a combinational function of the internal registers, `weight` and `bypass_mask`. The value shown in a cycle in which `shift_en` is high is the value that chain takes at the next rising edge.

No handshake exists at this block's edge: the scan shift clocking already paces the data. A shift happens in every cycle in which `shift_en` is high, and this block never pushes back.

Top module: `lts_scan_sel`

## Requirements
- R1: Synchronous active-high `rst` clears every per-chain history bit to 0 and sets the 40-bit random state to `RESET_SEED` (default 1).
- R2: The random state `s` is a 40-bit shift register with feedback. In a cycle with `shift_en` high and `seed_load` low, it becomes `{s[38:0], ^(s & 40'hA000140000)}`. With both inputs low it keeps its value.
- R3: `seed_load` high loads `seed` into the random state at the next edge, and takes priority over `shift_en`. An all-zero `seed` loads the value 1 instead.
- R4: The fresh bit offered to chain c is state bit `s[c]`.
- R5: The shared fresh decision is the AND of state bits `s[39]`, `s[38]`, … down to `s[40-w]`, using `w` bits in total. With `w = 0` the decision is always fresh.
- R6: A 1 in `bypass_mask[c]` makes `scan_in[c]` equal to `s[c]` whatever the fresh decision.
- R7: When the decision is not fresh and the mask bit is 0, `scan_in[c]` equals chain c's history bit.
- R8: Each history bit takes the current `scan_in[c]` at an edge where `shift_en` is high. Without `shift_en` it keeps its value, including while `seed_load` is high.
- R9: A change on `weight` or `bypass_mask` reaches `scan_in` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift cycle: history bits and random state advance at the edge |
| weight | input | 3 | Fresh-data probability is 2^-weight |
| bypass_mask | input | CHAINS | 1 per chain that always takes fresh data |
| seed_load | input | 1 | Load `seed` into the random state |
| seed | input | 40 | Seed value for the random state |
| scan_in | output | CHAINS | Bits presented to the scan chain inputs |

## Verification
`scan_in` settles within the same cycle as any change on `weight` or `bypass_mask`. The bench therefore changes these inputs on the falling edge and reads the output one nanosecond later, in the same half period. The effects of `shift_en`, `seed_load` and `rst` become visible one rising edge later. A bench-side model of the history bits and the random state is stepped right after each rising edge. The next comparison takes place in the following low phase, so every check sees exactly one register update.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int unsigned WEIGHT_W   = 3;
  localparam int unsigned MAX_WEIGHT = (1 << WEIGHT_W) - 1;
  typedef logic [WEIGHT_W-1:0] weight_t;
endpackage

// File: rtl/lts_lfsr.sv
// Shared random state: data bits from the low end, weighting bits from the top end.
module lts_lfsr #(
  parameter int unsigned W      = 40,
  parameter int unsigned CHAINS = 8,
  parameter int unsigned NWB    = 7,
  parameter logic [W-1:0] TAPS       = 40'hA000140000,
  parameter logic [W-1:0] RESET_SEED = 40'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              load,
  input  logic [W-1:0]      seed,
  output logic [CHAINS-1:0] data_bits,
  output logic [NWB-1:0]    weight_bits
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst)          state_q <= RESET_SEED;
    else if (load)    state_q <= (seed == '0) ? W'(1) : seed;   // R3: never lock at zero
    else if (advance) state_q <= {state_q[W-2:0], ^(state_q & TAPS)};  // R2
  end

  assign data_bits = state_q[CHAINS-1:0];  // R4

  for (genvar j = 0; j < NWB; j++) begin : g_wbit
    assign weight_bits[j] = state_q[W-1-j];
  end
endmodule

// File: rtl/lts_weight.sv
// Fresh decision: AND of the first `weight` weighting bits (R5).
module lts_weight
  import lts_pkg::*;
#(
  parameter int unsigned NWB = MAX_WEIGHT
) (
  input  weight_t        weight,
  input  logic [NWB-1:0] wbits,
  output logic           fresh
);
  logic [NWB-1:0] term;

  for (genvar j = 0; j < NWB; j++) begin : g_term
    // a bit beyond the selected count is masked to 1
    assign term[j] = wbits[j] | (32'(weight) <= j);
  end

  assign fresh = &term;
endmodule

// File: rtl/lts_chain_mux.sv
// One chain head: repeat-or-fresh selector plus its history bit.
module lts_chain_mux (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic fresh_all,
  input  logic bypass,
  input  logic rnd,
  output logic bit_out,
  output logic hist_q
);
  logic take_fresh;

  assign take_fresh = fresh_all | bypass;          // R6
  assign bit_out    = take_fresh ? rnd : hist_q;   // R7

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= 1'b0;     // R1
    else if (shift_en) hist_q <= bit_out;  // R8
  end
endmodule

// File: rtl/lts_scan_sel.sv
module lts_scan_sel
  import lts_pkg::*;
#(
  parameter int unsigned CHAINS = 8,
  parameter int unsigned LFSR_W = 40,
  parameter logic [LFSR_W-1:0] TAPS       = 40'hA000140000,
  parameter logic [LFSR_W-1:0] RESET_SEED = 40'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [2:0]        weight,
  input  logic [CHAINS-1:0] bypass_mask,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  output logic [CHAINS-1:0] scan_in
);
  localparam int unsigned NWB = MAX_WEIGHT;

  logic [CHAINS-1:0] rnd_data;
  logic [NWB-1:0]    rnd_wbits;
  logic [CHAINS-1:0] prev_q;
  logic              fresh_all;

  lts_lfsr #(
    .W(LFSR_W), .CHAINS(CHAINS), .NWB(NWB), .TAPS(TAPS), .RESET_SEED(RESET_SEED)
  ) u_lfsr (
    .clk(clk), .rst(rst), .advance(shift_en), .load(seed_load), .seed(seed),
    .data_bits(rnd_data), .weight_bits(rnd_wbits)
  );

  lts_weight #(.NWB(NWB)) u_weight (
    .weight(weight_t'(weight)), .wbits(rnd_wbits), .fresh(fresh_all)
  );

  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    lts_chain_mux u_mux (
      .clk(clk), .rst(rst), .shift_en(shift_en), .fresh_all(fresh_all),
      .bypass(bypass_mask[c]), .rnd(rnd_data[c]),
      .bit_out(scan_in[c]), .hist_q(prev_q[c])
    );
  end
endmodule

// File: rtl/lts_scan_sel_chk.sv
module lts_scan_sel_chk #(
  parameter int unsigned CHAINS = 8,
  parameter int unsigned LFSR_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_en,
  input logic              seed_load,
  input logic [2:0]        weight,
  input logic [CHAINS-1:0] bypass_mask,
  input logic [LFSR_W-1:0] seed,
  input logic [CHAINS-1:0] scan_in,
  input logic [CHAINS-1:0] rnd_data,
  input logic [6:0]        rnd_wbits,
  input logic [CHAINS-1:0] prev_q
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> prev_q == '0);

  p_idle_state_r2: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !seed_load) |=> $stable(rnd_data));

  p_seed_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed != '0) |=> rnd_data == $past(seed[CHAINS-1:0]));

  p_weight_zero_r5: assert property (@(posedge clk) disable iff (rst)
    weight == 3'd0 |-> scan_in == rnd_data);

  p_bypass_fresh_r6: assert property (@(posedge clk) disable iff (rst)
    ((scan_in ^ rnd_data) & bypass_mask) == '0);

  p_hold_prev_r7: assert property (@(posedge clk) disable iff (rst)
    (weight != 3'd0 && !rnd_wbits[0]) |-> ((scan_in ^ prev_q) & ~bypass_mask) == '0);

  p_prev_follow_r8: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> prev_q == $past(scan_in));

  p_prev_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(prev_q));
endmodule

bind lts_scan_sel lts_scan_sel_chk #(.CHAINS(CHAINS), .LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .seed_load(seed_load),
  .weight(weight), .bypass_mask(bypass_mask), .seed(seed), .scan_in(scan_in),
  .rnd_data(rnd_data), .rnd_wbits(rnd_wbits), .prev_q(prev_q)
);

// File: tb/tb_lts_scan_sel.sv
`timescale 1ns/1ps
module tb_lts_scan_sel;
  localparam int unsigned CH = 8;
  localparam int unsigned LW = 40;
  localparam logic [LW-1:0] TAPS = 40'hA000140000;

  logic clk = 1'b0;
  logic rst, shift_en, seed_load;
  logic [2:0] weight;
  logic [CH-1:0] bypass_mask;
  logic [LW-1:0] seed;
  logic [CH-1:0] scan_in;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // bench model, stepped from the requirements
  logic [LW-1:0] m_s;
  logic [CH-1:0] m_prev;

  always #4 clk = ~clk;

  lts_scan_sel #(.CHAINS(CH), .LFSR_W(LW)) dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .weight(weight),
    .bypass_mask(bypass_mask), .seed_load(seed_load), .seed(seed), .scan_in(scan_in)
  );

  typedef struct packed {
    logic          se;
    logic          sl;
    logic [2:0]    w;
    logic [CH-1:0] bm;
    logic [LW-1:0] sd;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 1'b1, 3'd0, 8'h00, 40'hC35A96F00D},
    '{1'b1, 1'b0, 3'd0, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd1, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd1, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd2, 8'h81, 40'h0},
    '{1'b1, 1'b0, 3'd2, 8'h81, 40'h0},
    '{1'b0, 1'b0, 3'd3, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd7, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd7, 8'hF0, 40'h0},
    '{1'b1, 1'b1, 3'd1, 8'h0F, 40'h7E00FF33AA},
    '{1'b1, 1'b0, 3'd1, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd4, 8'h3C, 40'h0},
    '{1'b0, 1'b0, 3'd0, 8'hFF, 40'h0},
    '{1'b1, 1'b0, 3'd5, 8'h00, 40'h0},
    '{1'b1, 1'b0, 3'd1, 8'h55, 40'h0},
    '{1'b1, 1'b0, 3'd0, 8'h00, 40'h0}
  };

  function automatic logic [CH-1:0] model_out(logic [LW-1:0] s, logic [CH-1:0] prev,
                                              logic [2:0] w, logic [CH-1:0] bm);
    logic fr = 1'b1;
    for (int j = 0; j < int'(w); j++) fr &= s[LW-1-j];
    for (int c = 0; c < CH; c++) model_out[c] = (fr | bm[c]) ? s[c] : prev[c];
  endfunction

  task automatic check(string req, logic [CH-1:0] act, logic [CH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: scan_in=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs are set at negedge; output compared 1 ns later; model steps after posedge
  task automatic step(string req, logic se, logic sl, logic [2:0] w,
                      logic [CH-1:0] bm, logic [LW-1:0] sd);
    logic [CH-1:0] e;
    shift_en = se; seed_load = sl; weight = w; bypass_mask = bm; seed = sd;
    #1;
    e = model_out(m_s, m_prev, w, bm);
    check(req, scan_in, e);
    @(posedge clk);
    if (se) m_prev = e;
    if (sl) m_s = (sd == '0) ? LW'(1) : sd;
    else if (se) m_s = {m_s[LW-2:0], ^(m_s & TAPS)};
    @(negedge clk);
  endtask

  task automatic probe(string req, logic [2:0] w, logic [CH-1:0] bm, logic [CH-1:0] exp);
    shift_en = 1'b0; seed_load = 1'b0; weight = w; bypass_mask = bm;
    #1;
    check(req, scan_in, exp);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; shift_en = 1'b0; seed_load = 1'b0; weight = 3'd0;
    bypass_mask = '0; seed = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_s = LW'(1); m_prev = '0;

    // R1: reset state seen through weight 0 (state bits) and weight 7 (history)
    probe("R1 reset state bits", 3'd0, 8'h00, 8'h01);
    probe("R1 reset history", 3'd7, 8'h00, 8'h00);
    // R9: same-cycle response to bypass change (R6 with history 0)
    probe("R9 bypass same cycle", 3'd7, 8'h01, 8'h01);

    // table walk: R2 R4 R5 R6 R7 R8 R3
    foreach (VEC[i])
      step($sformatf("R2/R3/R4/R5/R6/R7/R8 row %0d", i),
           VEC[i].se, VEC[i].sl, VEC[i].w, VEC[i].bm, VEC[i].sd);

    // R3: zero seed turns into 1
    step("R3 zero seed load", 1'b0, 1'b1, 3'd0, 8'h00, 40'h0);
    probe("R3 zero seed gives 1", 3'd0, 8'h00, 8'h01);

    // R5: all-ones state with weight 7 takes fresh data
    step("R3 load ones", 1'b0, 1'b1, 3'd0, 8'h00, {LW{1'b1}});
    probe("R5 weight 7 fresh", 3'd7, 8'h00, 8'hFF);

    // R7/R8: top bit 0 forces hold; shift a known history first
    step("R3 load low ones", 1'b0, 1'b1, 3'd0, 8'h00, 40'h00000000A5);
    step("R8 shift A5 in", 1'b1, 1'b0, 3'd0, 8'h00, 40'h0);
    step("R3 load top zero", 1'b0, 1'b1, 3'd0, 8'h00, 40'h000000005A);
    probe("R7 hold history", 3'd1, 8'h00, 8'hA5);
    probe("R6 bypass low nibble", 3'd1, 8'h0F, 8'hAA);
    probe("R4 weight 0 data bits", 3'd0, 8'h00, 8'h5A);

    // R8/R2: idle cycles change nothing
    repeat (3) step("R8 idle cycle", 1'b0, 1'b0, 3'd1, 8'h00, 40'h0);
    probe("R8 history kept idle", 3'd1, 8'h00, 8'hA5);
    probe("R2 state kept idle", 3'd0, 8'h00, 8'h5A);

    // R1: reset mid-run clears history
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    m_s = LW'(1); m_prev = '0;
    probe("R1 reset mid-run", 3'd1, 8'h00, 8'h00);

    // long run against the model
    for (int k = 0; k < 200; k++)
      step("R2/R5/R7/R8 long run", 1'b1, 1'b0, 3'(k % 8), 8'(k * 37), 40'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule